// File: doc/BRIEF.md
# Asynchronous SRAM controller

This block lets a synchronous host read and write a 2048 x 8 asynchronous static RAM. The RAM has active-low chip select, write enable and output enable. The host offers one access at a time through a request/ready handshake. An access carries an address, a write flag and write data, and a read returns its byte in a register together with a single-cycle valid pulse.

On the memory side the block drives the address lines and the three strobes. It also drives a data bus that is split into an output byte, an output-enable and an input byte, for a pad ring to combine. Every timing limit of the RAM is a parameter in nanoseconds. The block turns each limit into a cycle count by dividing by the clock period and rounding up, so a nonzero limit never becomes zero cycles. Writes are timed by the write-enable strobe.

Turnaround rules are enforced in logic:
- The address never moves while the chip is selected.
- The block's own data drivers never overlap a cycle in which the RAM may still be driving.
- A write that directly follows a read is preceded by a deselected cycle.

A parameter chooses whether output enable stays high for the whole write or stays low through it. In the second case the write pulse is lengthened and the drivers come on later.

Top module: `asram_ctrl`

## Requirements
- R1: After reset `host_ready` is 1, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are 1 and `mem_doe` is 0. Whenever `host_ready` is 1, all three strobes are high and `mem_doe` is 0.
- R2: Each timing value t becomes c(t) = ceil(t / CLK_NS) cycles, and 0 stays 0. Every duration below is expressed in these counts.
- R3: A read holds `mem_cs_n` and `mem_oe_n` low and `mem_we_n` high for max(c(T_AA), c(T_OE), c(T_RC)) cycles. `mem_din` is captured at the clock edge that ends this window. `host_rvalid` is 1 for exactly one cycle, the first cycle in which `host_ready` is back at 1, and `host_rdata` then holds the byte.
- R4: `mem_we_n` is low only while `mem_cs_n` is low. It falls c(T_AS) cycles after `mem_cs_n` falls. Every write pulse delivers its byte to the RAM.
- R5: With WR_OE_LOW = 0, `mem_oe_n` stays high through the whole write. The pulse lasts max(c(T_WP), c(T_DW), c(T_AW) - c(T_AS)) cycles, and `mem_doe` is 1 for all of it.
- R6: With WR_OE_LOW = 1, `mem_oe_n` is low during address setup and during the pulse. The pulse also covers c(T_WHZ) + c(T_DW). `mem_doe` stays 0 for the first c(T_WHZ) cycles of the pulse and is 1 for the rest.
- R7: `mem_doe` is never 1 in a cycle where `mem_cs_n` = 0, `mem_oe_n` = 0 and `mem_we_n` = 1. When WR_OE_LOW = 0 or T_WHZ > 0, it also never rises in the cycle right after such a cycle.
- R8: `mem_addr` does not change between two consecutive cycles in which `mem_cs_n` is low.
- R9: After the pulse, `mem_cs_n` stays low with `mem_we_n` high for max(c(T_DH), c(T_WR), c(T_WC) - c(T_AS) - pulse) cycles. `host_ready` is 0 from the accepting edge for setup + pulse + recovery cycles.
- R10: A write accepted right after a read adds one cycle with all strobes high before `mem_cs_n` falls, so the write is busy one extra cycle. A write after a write adds no such cycle.
- R11: Changes on `host_addr`, `host_wdata` and `host_wr` after the accepting edge have no effect on the access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_req | input | 1 | Access request, accepted on a rising edge while host_ready is 1 |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Word address |
| host_wdata | input | DATA_W | Write byte |
| host_ready | output | 1 | Idle and able to accept |
| host_rvalid | output | 1 | One-cycle pulse when read data is returned |
| host_rdata | output | DATA_W | Last byte read |
| mem_addr | output | ADDR_W | RAM address lines |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dout | output | DATA_W | Byte driven toward the RAM |
| mem_doe | output | 1 | Enable for the data drivers |
| mem_din | input | DATA_W | Byte read from the RAM |

## Verification
The bench builds two instances at a 4 ns clock.

The first uses the default 20 ns speed-grade values with output enable high during writes. This gives a 5-cycle read, a 4-cycle pulse stretched by the address-to-end-of-write time, and a 1-cycle recovery that comes from the write cycle time.

The second keeps output enable low during writes and sets address setup to 5 ns, write-to-high-Z to 11 ns and data hold to 3 ns. This brings within reach:
- a nonzero setup phase;
- a pulse stretched by high-Z plus data overlap;
- delayed driver turn-on;
- a recovery set by the data hold.

Both instances write and read back all 2048 addresses, and an interleaved read/write pass exercises the turnaround gap. A cycle-counting RAM model returns a poison byte when read early and counts short pulses, short data overlap, moving addresses and bus fights.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_RD,
    ST_WAS,
    ST_WPUL,
    ST_WREC
  } seq_st_e;

  // nanoseconds to clock cycles, rounded up; zero stays zero
  function automatic int ns_to_cyc(input int t_ns, input int clk_ns);
    if (t_ns <= 0) return 0;
    return (t_ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_tcount.sv
module asram_tcount #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_d,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    if (load)             cnt_d = load_val;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    else                  cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/asram_dpath.sv
module asram_dpath #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [DATA_W-1:0] mem_din,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q,
  output logic              rvalid_q
);

  // request fields: loaded only on the accepting edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= host_addr;
      wdata_q <= host_wdata;
    end
  end

  // read return register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else if (capture) rdata_q <= mem_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid_q <= 1'b0;
    else        rvalid_q <= capture;
  end

endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int CNT_W     = 3,
  parameter int L_RD      = 5,
  parameter int L_AS      = 0,
  parameter int L_WP      = 4,
  parameter int L_REC     = 1,
  parameter int DRV_FROM  = 0,
  parameter int WR_OE_LOW = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             wr,
  output logic             ready,
  output logic             accept,
  output logic             capture,
  output logic             cnt_load,
  output logic [CNT_W-1:0] cnt_val,
  input  logic [CNT_W-1:0] cnt_d,
  input  logic             cnt_zero,
  output logic             cs_n,
  output logic             we_n,
  output logic             oe_n,
  output logic             drv
);

  localparam logic [CNT_W-1:0] V_RD  = CNT_W'(L_RD - 1);
  localparam logic [CNT_W-1:0] V_AS  = CNT_W'((L_AS  > 0) ? L_AS  - 1 : 0);
  localparam logic [CNT_W-1:0] V_WP  = CNT_W'(L_WP - 1);
  localparam logic [CNT_W-1:0] V_REC = CNT_W'((L_REC > 0) ? L_REC - 1 : 0);
  localparam logic [CNT_W-1:0] DRV_LAST = CNT_W'(L_WP - 1 - DRV_FROM);
  localparam seq_st_e          WR_ST = (L_AS > 0) ? ST_WAS : ST_WPUL;
  localparam logic [CNT_W-1:0] WR_V  = (L_AS > 0) ? V_AS : V_WP;

  seq_st_e st_q, st_d;
  logic    last_rd_q, last_rd_d;
  logic    cs_n_d, we_n_d, oe_n_d, drv_d;

  // next state and counter control
  always_comb begin
    st_d      = st_q;
    last_rd_d = last_rd_q;
    cnt_load  = 1'b0;
    cnt_val   = '0;
    accept    = 1'b0;
    capture   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req) begin
          accept = 1'b1;
          cnt_load = 1'b1;
          if (wr) begin
            last_rd_d = 1'b0;
            if (last_rd_q) begin
              st_d    = ST_TURN;
              cnt_val = '0;
            end else begin
              st_d    = WR_ST;
              cnt_val = WR_V;
            end
          end else begin
            st_d    = ST_RD;
            cnt_val = V_RD;
          end
        end
      end
      ST_TURN: begin
        st_d     = WR_ST;
        cnt_load = 1'b1;
        cnt_val  = WR_V;
      end
      ST_RD: begin
        if (cnt_zero) begin
          capture   = 1'b1;
          last_rd_d = 1'b1;
          st_d      = ST_IDLE;
        end
      end
      ST_WAS: begin
        if (cnt_zero) begin
          st_d     = ST_WPUL;
          cnt_load = 1'b1;
          cnt_val  = V_WP;
        end
      end
      ST_WPUL: begin
        if (cnt_zero) begin
          if (L_REC > 0) begin
            st_d     = ST_WREC;
            cnt_load = 1'b1;
            cnt_val  = V_REC;
          end else begin
            st_d = ST_IDLE;
          end
        end
      end
      ST_WREC: begin
        if (cnt_zero) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // strobe decode from the next state, registered below
  always_comb begin
    cs_n_d = !(st_d inside {ST_RD, ST_WAS, ST_WPUL, ST_WREC});
    we_n_d = (st_d != ST_WPUL);
    oe_n_d = !((st_d == ST_RD) ||
               ((WR_OE_LOW != 0) && (st_d inside {ST_WAS, ST_WPUL})));
    drv_d  = ((st_d == ST_WPUL) && (cnt_d <= DRV_LAST)) || (st_d == ST_WREC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      last_rd_q <= 1'b0;
      cs_n      <= 1'b1;
      we_n      <= 1'b1;
      oe_n      <= 1'b1;
      drv       <= 1'b0;
    end else begin
      st_q      <= st_d;
      last_rd_q <= last_rd_d;
      cs_n      <= cs_n_d;
      we_n      <= we_n_d;
      oe_n      <= oe_n_d;
      drv       <= drv_d;
    end
  end

  assign ready = (st_q == ST_IDLE);

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 8,
  parameter int CLK_NS    = 4,
  parameter int T_RC      = 20,
  parameter int T_AA      = 19,
  parameter int T_OE      = 10,
  parameter int T_WC      = 20,
  parameter int T_WP      = 12,
  parameter int T_DW      = 12,
  parameter int T_AW      = 15,
  parameter int T_AS      = 0,
  parameter int T_WHZ     = 8,
  parameter int T_DH      = 0,
  parameter int T_WR      = 0,
  parameter int WR_OE_LOW = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_ready,
  output logic              host_rvalid,
  output logic [DATA_W-1:0] host_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_doe,
  input  logic [DATA_W-1:0] mem_din
);

  localparam int C_RC  = ns_to_cyc(T_RC,  CLK_NS);
  localparam int C_AA  = ns_to_cyc(T_AA,  CLK_NS);
  localparam int C_OE  = ns_to_cyc(T_OE,  CLK_NS);
  localparam int C_WC  = ns_to_cyc(T_WC,  CLK_NS);
  localparam int C_WP  = ns_to_cyc(T_WP,  CLK_NS);
  localparam int C_DW  = ns_to_cyc(T_DW,  CLK_NS);
  localparam int C_AW  = ns_to_cyc(T_AW,  CLK_NS);
  localparam int C_AS  = ns_to_cyc(T_AS,  CLK_NS);
  localparam int C_WHZ = ns_to_cyc(T_WHZ, CLK_NS);
  localparam int C_DH  = ns_to_cyc(T_DH,  CLK_NS);
  localparam int C_WR  = ns_to_cyc(T_WR,  CLK_NS);

  localparam int L_RD  = imax(imax(C_AA, C_OE), imax(C_RC, 1));
  localparam int L_WP0 = imax(imax(C_WP, C_DW), imax(C_AW - C_AS, 1));
  localparam int L_WP  = imax(L_WP0, (WR_OE_LOW != 0) ? C_WHZ + C_DW : 0);
  localparam int L_REC = imax(imax(C_DH, C_WR), C_WC - C_AS - L_WP);
  localparam int DRV_FROM = (WR_OE_LOW != 0) ? C_WHZ : 0;
  localparam int L_MAX = imax(imax(L_RD, L_WP), imax(C_AS, L_REC));
  localparam int CNT_W = $clog2(L_MAX + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic             accept, capture, cnt_load, cnt_zero;
  logic [CNT_W-1:0] cnt_val, cnt_d;

  asram_tcount #(.CNT_W(CNT_W)) u_tcount (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .cnt_d    (cnt_d),
    .zero     (cnt_zero)
  );

  asram_seq #(
    .CNT_W     (CNT_W),
    .L_RD      (L_RD),
    .L_AS      (C_AS),
    .L_WP      (L_WP),
    .L_REC     (L_REC),
    .DRV_FROM  (DRV_FROM),
    .WR_OE_LOW (WR_OE_LOW)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .req      (host_req),
    .wr       (host_wr),
    .ready    (host_ready),
    .accept   (accept),
    .capture  (capture),
    .cnt_load (cnt_load),
    .cnt_val  (cnt_val),
    .cnt_d    (cnt_d),
    .cnt_zero (cnt_zero),
    .cs_n     (mem_cs_n),
    .we_n     (mem_we_n),
    .oe_n     (mem_oe_n),
    .drv      (mem_doe)
  );

  asram_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .accept     (accept),
    .capture    (capture),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .mem_din    (mem_din),
    .addr_q     (mem_addr),
    .wdata_q    (mem_dout),
    .rdata_q    (host_rdata),
    .rvalid_q   (host_rvalid)
  );

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int ADDR_W    = 11,
  parameter int WR_OE_LOW = 0,
  parameter int T_WHZ     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_ready,
  input logic              host_rvalid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_doe
);

  // R1
  idle_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |-> (mem_cs_n && mem_we_n && mem_oe_n && !mem_doe));

  // R4
  we_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_cs_n);

  // R7
  no_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_doe |-> !(!mem_cs_n && !mem_oe_n && mem_we_n));

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr));

  // R3
  rvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rvalid |=> !host_rvalid);

  // R3
  rvalid_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rvalid |-> host_ready);

  generate
    if (WR_OE_LOW == 0 || T_WHZ > 0) begin : g_gap
      // R7
      drv_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_doe) |-> !$past(!mem_cs_n && !mem_oe_n && mem_we_n));
    end
    if (WR_OE_LOW == 0) begin : g_oe_high
      // R5
      oe_high_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);
    end
  endgenerate

endmodule

bind asram_ctrl asram_ctrl_chk #(
  .ADDR_W    (ADDR_W),
  .WR_OE_LOW (WR_OE_LOW),
  .T_WHZ     (T_WHZ)
) u_asram_ctrl_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .host_ready  (host_ready),
  .host_rvalid (host_rvalid),
  .mem_addr    (mem_addr),
  .mem_cs_n    (mem_cs_n),
  .mem_we_n    (mem_we_n),
  .mem_oe_n    (mem_oe_n),
  .mem_doe     (mem_doe)
);

// File: tb/asram_ctrl_model.sv
// Cycle-counting RAM model, sampled on falling clock edges.
module asram_ctrl_model #(
  parameter int AW       = 11,
  parameter int DW       = 8,
  parameter int NEED_RD  = 5,
  parameter int NEED_WP  = 3,
  parameter int NEED_DW  = 3,
  parameter int NEED_WHZ = 0
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  input  logic          cs_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [DW-1:0] dout,
  input  logic          doe,
  output logic [DW-1:0] din,
  output int            e_wp,
  output int            e_dw,
  output int            e_addr,
  output int            e_fight,
  output int            n_wr
);

  localparam logic [DW-1:0] POISON = DW'(8'hEE);

  logic [DW-1:0] mem [1 << AW];
  logic [AW-1:0] addr_prev;
  logic [DW-1:0] wbuf;
  int rd_age, we_age, dw_age;

  initial begin
    e_wp = 0; e_dw = 0; e_addr = 0; e_fight = 0; n_wr = 0;
    rd_age = 0; we_age = 0; dw_age = 0;
    addr_prev = '0; wbuf = '0;
    for (int i = 0; i < (1 << AW); i++) mem[i] = POISON;
  end

  always @(negedge clk) begin
    if (!cs_n && !we_n) begin
      if (we_age > 0 && addr != addr_prev) e_addr++;
      we_age++;
      if (doe) begin
        if (dw_age > 0 && dout == wbuf) dw_age++;
        else dw_age = 1;
        wbuf = dout;
        if (!oe_n && we_age <= NEED_WHZ) e_fight++;
      end else begin
        dw_age = 0;
      end
    end else begin
      if (we_age > 0) begin
        n_wr++;
        if (we_age < NEED_WP) e_wp++;
        if (dw_age < NEED_DW) e_dw++;
        else mem[addr_prev] = wbuf;
      end
      we_age = 0;
      dw_age = 0;
    end
    if (!cs_n && we_n && !oe_n && doe) e_fight++;
    if (!cs_n && !oe_n && we_n) begin
      if (rd_age > 0 && addr == addr_prev) rd_age++;
      else rd_age = 1;
    end else begin
      rd_age = 0;
    end
    if (!cs_n && !we_n && we_age > 1 && addr != addr_prev) e_addr++;
    addr_prev = addr;
  end

  assign din = (rd_age >= NEED_RD) ? mem[addr] : POISON;

endmodule

// File: tb/asram_ctrl_bench.sv
`timescale 1ns/1ps
module asram_ctrl_bench;

  localparam int CLK_NS = 4;
  localparam int AW = 11;
  localparam int DW = 8;
  localparam int NWORDS = 1 << AW;
  localparam int NALT = 128;
  localparam int WD_CYCLES = 180000;

  // timing values shared by both instances, plus per-instance ones
  localparam int T_RC = 20, T_AA = 19, T_OE = 10, T_WC = 20;
  localparam int T_WP = 12, T_DW = 12, T_AW = 15, T_WR = 0;
  localparam int AS0 = 0, WHZ0 = 8,  DH0 = 0;
  localparam int AS1 = 5, WHZ1 = 11, DH1 = 3;

  function automatic int cy(input int ns);
    return (ns == 0) ? 0 : (ns + CLK_NS - 1) / CLK_NS;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  logic clk, rst_n;
  logic          req   [2];
  logic          wr    [2];
  logic [AW-1:0] haddr [2];
  logic [DW-1:0] hwd   [2];
  logic          rdy   [2];
  logic          rv    [2];
  logic [DW-1:0] rdat  [2];
  logic [AW-1:0] maddr [2];
  logic          cs_n  [2];
  logic          we_n  [2];
  logic          oe_n  [2];
  logic [DW-1:0] mdo   [2];
  logic          mdoe  [2];
  logic [DW-1:0] mdi   [2];
  int e_wp [2], e_dw [2], e_addr [2], e_fight [2], n_wr [2];

  int n_chk, n_err;
  bit done;

  initial clk = 1'b0;
  always #(CLK_NS / 2) clk = ~clk;

  asram_ctrl #(
    .CLK_NS(CLK_NS), .T_RC(T_RC), .T_AA(T_AA), .T_OE(T_OE), .T_WC(T_WC),
    .T_WP(T_WP), .T_DW(T_DW), .T_AW(T_AW), .T_AS(AS0), .T_WHZ(WHZ0),
    .T_DH(DH0), .T_WR(T_WR), .WR_OE_LOW(0)
  ) u_asram_ctrl (
    .clk(clk), .rst_n(rst_n), .host_req(req[0]), .host_wr(wr[0]),
    .host_addr(haddr[0]), .host_wdata(hwd[0]), .host_ready(rdy[0]),
    .host_rvalid(rv[0]), .host_rdata(rdat[0]), .mem_addr(maddr[0]),
    .mem_cs_n(cs_n[0]), .mem_we_n(we_n[0]), .mem_oe_n(oe_n[0]),
    .mem_dout(mdo[0]), .mem_doe(mdoe[0]), .mem_din(mdi[0])
  );

  asram_ctrl #(
    .CLK_NS(CLK_NS), .T_RC(T_RC), .T_AA(T_AA), .T_OE(T_OE), .T_WC(T_WC),
    .T_WP(T_WP), .T_DW(T_DW), .T_AW(T_AW), .T_AS(AS1), .T_WHZ(WHZ1),
    .T_DH(DH1), .T_WR(T_WR), .WR_OE_LOW(1)
  ) u_asram_ctrl_oelow (
    .clk(clk), .rst_n(rst_n), .host_req(req[1]), .host_wr(wr[1]),
    .host_addr(haddr[1]), .host_wdata(hwd[1]), .host_ready(rdy[1]),
    .host_rvalid(rv[1]), .host_rdata(rdat[1]), .mem_addr(maddr[1]),
    .mem_cs_n(cs_n[1]), .mem_we_n(we_n[1]), .mem_oe_n(oe_n[1]),
    .mem_dout(mdo[1]), .mem_doe(mdoe[1]), .mem_din(mdi[1])
  );

  asram_ctrl_model #(.AW(AW), .DW(DW), .NEED_RD(cy(19)), .NEED_WP(cy(T_WP)),
    .NEED_DW(cy(T_DW)), .NEED_WHZ(0)) u_model0 (
    .clk(clk), .addr(maddr[0]), .cs_n(cs_n[0]), .we_n(we_n[0]), .oe_n(oe_n[0]),
    .dout(mdo[0]), .doe(mdoe[0]), .din(mdi[0]), .e_wp(e_wp[0]), .e_dw(e_dw[0]),
    .e_addr(e_addr[0]), .e_fight(e_fight[0]), .n_wr(n_wr[0])
  );

  asram_ctrl_model #(.AW(AW), .DW(DW), .NEED_RD(cy(19)), .NEED_WP(cy(T_WP)),
    .NEED_DW(cy(T_DW)), .NEED_WHZ(cy(WHZ1))) u_model1 (
    .clk(clk), .addr(maddr[1]), .cs_n(cs_n[1]), .we_n(we_n[1]), .oe_n(oe_n[1]),
    .dout(mdo[1]), .doe(mdoe[1]), .din(mdi[1]), .e_wp(e_wp[1]), .e_dw(e_dw[1]),
    .e_addr(e_addr[1]), .e_fight(e_fight[1]), .n_wr(n_wr[1])
  );

  // expected figures from the requirements
  function automatic int x_as(input int k);  return cy(k ? AS1 : AS0); endfunction
  function automatic int x_rd();
    return mx(mx(cy(T_AA), cy(T_OE)), cy(T_RC));
  endfunction
  function automatic int x_wp(input int k);
    int p;
    p = mx(mx(cy(T_WP), cy(T_DW)), cy(T_AW) - x_as(k));
    if (k == 1) p = mx(p, cy(WHZ1) + cy(T_DW));
    return p;
  endfunction
  function automatic int x_rec(input int k);
    return mx(mx(cy(k ? DH1 : DH0), cy(T_WR)), cy(T_WC) - x_as(k) - x_wp(k));
  endfunction
  function automatic logic [DW-1:0] pat(input int k, input int a, input int pass);
    return DW'(a * 29 + pass * 101 + k * 7 + (a >> 5));
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // observations of the last access
  int o_busy, o_we, o_gap, o_drv, o_oe, o_rvbusy, o_rvend;
  logic [DW-1:0] o_rd;

  task automatic do_op(input int k, input bit w, input logic [AW-1:0] a,
                       input logic [DW-1:0] d);
    bit saw_cs;
    @(negedge clk);
    while (!rdy[k]) @(negedge clk);
    req[k] = 1'b1; wr[k] = w; haddr[k] = a; hwd[k] = d;
    @(posedge clk);
    #1;
    // R11: scramble host inputs right after acceptance
    req[k] = 1'b0; wr[k] = !w; haddr[k] = ~a; hwd[k] = ~d;
    o_busy = 0; o_we = 0; o_gap = 0; o_drv = 0; o_oe = 0; o_rvbusy = 0;
    saw_cs = 1'b0;
    forever begin
      @(negedge clk);
      if (rdy[k] || o_busy > 100) break;
      o_busy++;
      if (!we_n[k]) o_we++;
      if (!we_n[k] && mdoe[k]) o_drv++;
      if (!we_n[k] && !oe_n[k]) o_oe++;
      if (cs_n[k] && !saw_cs) o_gap++;
      if (!cs_n[k]) saw_cs = 1'b1;
      if (rv[k]) o_rvbusy++;
    end
    o_rvend = int'(rv[k]);
    o_rd = rdat[k];
  endtask

  task automatic check_write(input int k, input bit after_rd);
    int eb;
    eb = x_as(k) + x_wp(k) + x_rec(k) + (after_rd ? 1 : 0);
    // R9 / R10 / R2
    chk(o_busy == eb, after_rd ? "R10" : "R9", "write busy cycles", o_busy, eb);
    // R10
    chk(o_gap == (after_rd ? 1 : 0) + x_as(k) * 0, "R10", "deselected gap", o_gap,
        after_rd ? 1 : 0);
    // R5 / R6
    chk(o_we == x_wp(k), k ? "R6" : "R5", "write pulse cycles", o_we, x_wp(k));
    chk(o_drv == x_wp(k) - (k ? cy(WHZ1) : 0), k ? "R6" : "R5",
        "driver cycles in pulse", o_drv, x_wp(k) - (k ? cy(WHZ1) : 0));
    chk(o_oe == (k ? x_wp(k) : 0), k ? "R6" : "R5", "oe low in pulse", o_oe,
        k ? x_wp(k) : 0);
    // R3: no read pulse on a write
    chk(o_rvbusy == 0 && o_rvend == 0, "R3", "rvalid on write", o_rvend, 0);
  endtask

  task automatic check_read(input int k, input logic [DW-1:0] exp);
    // R3 / R2
    chk(o_busy == x_rd(), "R3", "read busy cycles", o_busy, x_rd());
    chk(o_rvend == 1 && o_rvbusy == 0, "R3", "rvalid pulse", o_rvend, 1);
    // R4 / R11: byte written at latched address comes back
    chk(o_rd == exp, "R11", "read data", int'(o_rd), int'(exp));
  endtask

  task automatic run_mode(input int k);
    // R1
    chk(rdy[k] == 1'b1, "R1", "ready after reset", int'(rdy[k]), 1);
    chk(cs_n[k] && we_n[k] && oe_n[k], "R1", "strobes after reset",
        int'({cs_n[k], we_n[k], oe_n[k]}), 7);
    chk(mdoe[k] == 1'b0, "R1", "drivers after reset", int'(mdoe[k]), 0);
    // R4: full write sweep, write after write
    for (int a = 0; a < NWORDS; a++) begin
      do_op(k, 1'b1, AW'(a), pat(k, a, 0));
      check_write(k, a == 0 ? 1'b0 : 1'b0);
    end
    // R3: full read sweep
    for (int a = 0; a < NWORDS; a++) begin
      do_op(k, 1'b0, AW'(a), '0);
      check_read(k, pat(k, a, 0));
    end
    // R10: read, then write after read, then read back
    for (int i = 0; i < NALT; i++) begin
      int a;
      a = (i * 97 + 13) % NWORDS;
      do_op(k, 1'b0, AW'(a), '0);
      check_read(k, pat(k, a, 0));
      do_op(k, 1'b1, AW'(a), pat(k, a, 1));
      check_write(k, 1'b1);
      do_op(k, 1'b0, AW'(a), '0);
      check_read(k, pat(k, a, 1));
    end
    repeat (3) @(negedge clk);
    // R4 / R6 / R7 / R8 from the model's counters
    chk(n_wr[k] == NWORDS + NALT, "R4", "writes seen by RAM", n_wr[k], NWORDS + NALT);
    chk(e_wp[k] == 0, "R4", "short write pulses", e_wp[k], 0);
    chk(e_dw[k] == 0, "R6", "short data overlap", e_dw[k], 0);
    chk(e_addr[k] == 0, "R8", "address moves in pulse", e_addr[k], 0);
    chk(e_fight[k] == 0, "R7", "bus fights", e_fight[k], 0);
  endtask

  initial begin
    n_chk = 0; n_err = 0; done = 1'b0;
    for (int k = 0; k < 2; k++) begin
      req[k] = 1'b0; wr[k] = 1'b0; haddr[k] = '0; hwd[k] = '0;
    end
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    // R1: idle values while reset is held
    chk(rdy[0] && cs_n[0] && we_n[0] && oe_n[0] && !mdoe[0], "R1",
        "idle in reset", int'(rdy[0]), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_mode(0);
    run_mode(1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", WD_CYCLES, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule